// File: doc/BRIEF.md
# Cluster L2 Power-Up Sequencer

This block brings the shared second-level cache of a processor cluster, together with its snoop-control array, out of the powered-down state. A one-cycle start pulse launches it. When the head-switch status input already reports the cache as powered, the block skips the work and signals completion in the next cycle. Otherwise it walks a fixed series of steps. It sets the clamps, the head switches and the resets, and it opens a debug-reset override window. It then releases the array clamps, turns on the array head switches, enables the core clock branch and drops the main head-switch clamp. After that it closes the override window, releases the resets, waits a long settling time and finally requests the supply and hands the clock branch to hardware control.

Timed waits are measured in microseconds. A shared prescaler divides the clock by `CLK_PER_US` and restarts at every wait, and one countdown timer serves all the waits. The outputs are a 32-bit power-control word, a 32-bit override word and two clock-branch control bits. The cache arrays, the clock generator and the supply controller lie outside this block.

Top module: `l2_pwrup_seq`

## Requirements
- R1: After reset the control word is 0x00001500 (bit 8 clamp, bit 10 head-switch reset, bit 12 system reset set), the override word is 0, `clk_en_o`, `clk_hw_o`, `busy_o` and `done_o` are 0.
- R2: A start pulse seen in idle while `l2_hs_up_i` is 1 raises `done_o` for exactly the next cycle and leaves the control word, the override word and both clock bits unchanged; `busy_o` stays 0.
- R3: A start pulse seen in idle while `l2_hs_up_i` is 0 makes, in the next cycle, the control word hold bits 8, 9, 10, 12, 14, 15 with `HS_COUNT` (16) in the count field starting at bit 16. It also sets override word bit 22, clears both clock bits and bit 28, and raises `busy_o`.
- R4: When the first short wait ends, bits 14 and 15 (array clamps) clear; in the following cycle bits 0 and 1 (array head switches) set.
- R5: When the second short wait ends, `clk_en_o` rises; in the following cycle bit 8 (head-switch clamp) clears.
- R6: When the third short wait ends, override bit 22 clears; in the following cycle bits 10 and 12 clear together.
- R7: Each wait lasts a fixed time. From the output change that arms a wait to the next output change is `SHORT_US*CLK_PER_US+1` cycles for the short waits and `LONG_US*CLK_PER_US+1` cycles for the long wait.
- R8: When the long wait ends, bit 28 (supply request) sets. In the following cycle `clk_hw_o` rises while `clk_en_o` stays 1, `done_o` is 1 for that one cycle and `busy_o` falls.
- R9: Bits 2, 11, 13 and every bit not named in R1 to R8 stay 0 at all times. After completion all outputs hold their final values (control word 0x10100203) until the next start.
- R10: While busy, start pulses and changes of `l2_hs_up_i` have no effect on any output or on the step timing.
- R11: A start in idle after a completed sequence, with the status low, reruns the sequence from the R3 step, which drops the supply request and both clock bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the power-up sequence |
| l2_hs_up_i | input | 1 | Head-switch status: L2 already powered |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse (skip or full path) |
| l2_ctl_o | output | 32 | L2 power-control word |
| dbg_ovr_o | output | 32 | Override word; bit 22 is the debug-reset override |
| clk_en_o | output | 1 | Core clock-branch enable |
| clk_hw_o | output | 1 | Clock-branch hardware control |

## Verification
A start pulse can arrive in the cycle that performs the final hand-off step. The hand-off and the completion pulse also share one cycle, so a start in the cycle right after can meet a `done_o` that is still high. The bench sweeps start pulses, each paired with a status flip, across every eleventh cycle of a busy run and also into the last busy cycle, and it expects the output trace to match the undisturbed one exactly. It also drives a start in the cycle where `done_o` is high and expects a fresh run to begin with the clock bits and the supply request cleared.

// File: rtl/l2pu_pkg.sv
package l2pu_pkg;

    localparam int CTL_W = 32;

    // control word bit positions (decoded by neighbouring power logic)
    localparam int B_ARR_HS    = 0;
    localparam int B_SNP_HS    = 1;
    localparam int B_RST_DIS   = 2;
    localparam int B_CLAMP     = 8;
    localparam int B_HS_EN     = 9;
    localparam int B_HS_RST    = 10;
    localparam int B_SLEEP     = 11;
    localparam int B_SYS_RST   = 12;
    localparam int B_RET_SLP   = 13;
    localparam int B_SNP_CLAMP = 14;
    localparam int B_ARR_CLAMP = 15;
    localparam int B_CNT_LSB   = 16;
    localparam int CNT_W       = 8;
    localparam int B_SUPPLY    = 28;

    // override word bit position
    localparam int B_DBG_OVR   = 22;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_PRE,
        ST_ARR_ON,
        ST_WAIT_ARR,
        ST_HS_UNCLAMP,
        ST_WAIT_UNCLAMP,
        ST_RST_REL,
        ST_WAIT_SUPPLY,
        ST_HANDOFF
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [CTL_W-1:0]  ctl;
        logic              ovr;
        logic              clk_en;
        logic              clk_hw;
        logic              done;
    } seq_regs_t;

endpackage

// File: rtl/l2pu_usec_tick.sv
module l2pu_usec_tick #(
    parameter int CLK_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] presc_d, presc_q;

    always_comb begin
        tick_o  = (presc_q == LAST);
        presc_d = presc_q;
        if (restart_i || tick_o) begin
            presc_d = '0;
        end else begin
            presc_d = presc_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end

    // prescaler never runs past the last count of a microsecond
    assert_presc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= LAST);

    // a restart always brings the prescaler back to zero
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (presc_q == '0));

endmodule

// File: rtl/l2pu_wait_timer.sv
module l2pu_wait_timer #(
    parameter int UW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [UW-1:0] load_us_i,
    input  logic          tick_i,
    output logic          expired_o
);
    logic [UW-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (arm_i) begin
            rem_d = load_us_i;
        end else if (tick_i && (rem_q != '0)) begin
            rem_d = rem_q - UW'(1);
        end
        expired_o = (rem_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    // without a fresh load the remaining time only counts down
    assert_no_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (rem_q <= $past(rem_q)));

    // a load is never zero, so a wait cannot end in the cycle it starts
    assert_nonzero_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |-> (load_us_i != '0));

endmodule

// File: rtl/l2pu_step_fsm.sv
module l2pu_step_fsm
    import l2pu_pkg::*;
#(
    parameter int SHORT_US = 2,
    parameter int LONG_US  = 54,
    parameter int HS_COUNT = 16,
    parameter int UW       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hs_up_i,
    input  logic             expired_i,
    output logic             arm_o,
    output logic [UW-1:0]    arm_us_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             ovr_o,
    output logic             clk_en_o,
    output logic             clk_hw_o
);
    localparam logic [CTL_W-1:0] RST_WORD =
        (CTL_W'(1) << B_CLAMP) | (CTL_W'(1) << B_HS_RST) | (CTL_W'(1) << B_SYS_RST);

    localparam logic [CTL_W-1:0] CNT_FIELD =
        CTL_W'((HS_COUNT % (1 << CNT_W))) << B_CNT_LSB;

    localparam logic [CTL_W-1:0] INIT_WORD = RST_WORD
        | (CTL_W'(1) << B_HS_EN)
        | (CTL_W'(1) << B_SNP_CLAMP)
        | (CTL_W'(1) << B_ARR_CLAMP)
        | CNT_FIELD;

    seq_regs_t d, q;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        arm_o    = 1'b0;
        arm_us_o = UW'(SHORT_US);
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (hs_up_i) begin
                        d.done = 1'b1;
                    end else begin
                        d.ctl    = INIT_WORD;
                        d.ovr    = 1'b1;
                        d.clk_en = 1'b0;
                        d.clk_hw = 1'b0;
                        arm_o    = 1'b1;
                        d.state  = ST_WAIT_PRE;
                    end
                end
            end
            ST_WAIT_PRE: begin
                if (expired_i) begin
                    d.ctl[B_SNP_CLAMP] = 1'b0;
                    d.ctl[B_ARR_CLAMP] = 1'b0;
                    d.state            = ST_ARR_ON;
                end
            end
            ST_ARR_ON: begin
                d.ctl[B_ARR_HS] = 1'b1;
                d.ctl[B_SNP_HS] = 1'b1;
                arm_o           = 1'b1;
                d.state         = ST_WAIT_ARR;
            end
            ST_WAIT_ARR: begin
                if (expired_i) begin
                    d.clk_en = 1'b1;
                    d.state  = ST_HS_UNCLAMP;
                end
            end
            ST_HS_UNCLAMP: begin
                d.ctl[B_CLAMP] = 1'b0;
                arm_o          = 1'b1;
                d.state        = ST_WAIT_UNCLAMP;
            end
            ST_WAIT_UNCLAMP: begin
                if (expired_i) begin
                    d.ovr   = 1'b0;
                    d.state = ST_RST_REL;
                end
            end
            ST_RST_REL: begin
                d.ctl[B_HS_RST]  = 1'b0;
                d.ctl[B_SYS_RST] = 1'b0;
                arm_o            = 1'b1;
                arm_us_o         = UW'(LONG_US);
                d.state          = ST_WAIT_SUPPLY;
            end
            ST_WAIT_SUPPLY: begin
                if (expired_i) begin
                    d.ctl[B_SUPPLY] = 1'b1;
                    d.state         = ST_HANDOFF;
                end
            end
            ST_HANDOFF: begin
                d.clk_hw = 1'b1;
                d.done   = 1'b1;
                d.state  = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.ctl    <= RST_WORD;
            q.ovr    <= 1'b0;
            q.clk_en <= 1'b0;
            q.clk_hw <= 1'b0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy_o   = (q.state != ST_IDLE);
        done_o   = q.done;
        ctl_o    = q.ctl;
        ovr_o    = q.ovr;
        clk_en_o = q.clk_en;
        clk_hw_o = q.clk_hw;
    end

    // skip path: completion next cycle with nothing else moving
    assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start_i && hs_up_i) |=>
            (done_o && !busy_o && $stable(ctl_o) && $stable(ovr_o)
             && $stable(clk_en_o) && $stable(clk_hw_o)));

    // launch step: clamps and override up, clocks down, busy
    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start_i && !hs_up_i) |=>
            (busy_o && ctl_o[B_CLAMP] && ctl_o[B_SNP_CLAMP] && ctl_o[B_ARR_CLAMP]
             && ovr_o && !clk_en_o && !clk_hw_o && !ctl_o[B_SUPPLY]));

    // array head switches only ever on with their clamps released
    assert_arr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[B_ARR_HS] || ctl_o[B_SNP_HS]) |-> (!ctl_o[B_SNP_CLAMP] && !ctl_o[B_ARR_CLAMP]));

    // head-switch clamp released only once the clock branch runs
    assert_clk_before_unclamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[B_CLAMP] |-> clk_en_o);

    // resets released only after the override window has closed
    assert_ovr_before_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[B_HS_RST] |-> !ovr_o);

    // supply request only after both resets are released
    assert_supply_after_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[B_SUPPLY] |-> (!ctl_o[B_HS_RST] && !ctl_o[B_SYS_RST]));

    // hardware clock control keeps the enable on
    assert_hw_keeps_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hw_o |-> clk_en_o);

    // completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // unused mode bits never driven
    assert_idle_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o[B_RST_DIS] && !ctl_o[B_SLEEP] && !ctl_o[B_RET_SLP]));

    // in idle without a start nothing moves
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && !start_i) |=>
            ($stable(ctl_o) && $stable(ovr_o) && $stable(clk_en_o) && $stable(clk_hw_o)));

endmodule

// File: rtl/l2_pwrup_seq.sv
module l2_pwrup_seq
    import l2pu_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int SHORT_US   = 2,
    parameter int LONG_US    = 54,
    parameter int HS_COUNT   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        l2_hs_up_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [31:0] l2_ctl_o,
    output logic [31:0] dbg_ovr_o,
    output logic        clk_en_o,
    output logic        clk_hw_o
);
    localparam int MAX_US = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
    localparam int UW     = $clog2(MAX_US + 1);

    logic          tick;
    logic          arm;
    logic [UW-1:0] arm_us;
    logic          expired;
    logic          ovr_bit;

    l2pu_usec_tick #(
        .CLK_PER_US (CLK_PER_US)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (arm),
        .tick_o    (tick)
    );

    l2pu_wait_timer #(
        .UW (UW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .load_us_i (arm_us),
        .tick_i    (tick),
        .expired_o (expired)
    );

    l2pu_step_fsm #(
        .SHORT_US (SHORT_US),
        .LONG_US  (LONG_US),
        .HS_COUNT (HS_COUNT),
        .UW       (UW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .hs_up_i   (l2_hs_up_i),
        .expired_i (expired),
        .arm_o     (arm),
        .arm_us_o  (arm_us),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .ctl_o     (l2_ctl_o),
        .ovr_o     (ovr_bit),
        .clk_en_o  (clk_en_o),
        .clk_hw_o  (clk_hw_o)
    );

    always_comb begin
        dbg_ovr_o            = '0;
        dbg_ovr_o[B_DBG_OVR] = ovr_bit;
    end

    // override word carries only its one defined bit
    assert_ovr_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dbg_ovr_o) <= 1);

    // timer armed only during a running sequence or at launch
    assert_arm_context_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> busy_o);

endmodule

// File: tb/tb_l2_pwrup_seq.sv
`timescale 1ns/1ps
module tb_l2_pwrup_seq;
    localparam int P  = 3;
    localparam int C1 = 2*P + 1;
    localparam int C2 = C1 + 1;
    localparam int C3 = C2 + 2*P + 1;
    localparam int C4 = C3 + 1;
    localparam int C5 = C4 + 2*P + 1;
    localparam int C6 = C5 + 1;
    localparam int C7 = C6 + 54*P + 1;
    localparam int C8 = C7 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hs_up = 1'b0;
    logic        busy, done, clk_en, clk_hw;
    logic [31:0] ctl, ovr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    l2_pwrup_seq #(.CLK_PER_US(P)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .l2_hs_up_i (hs_up),
        .busy_o     (busy),
        .done_o     (done),
        .l2_ctl_o   (ctl),
        .dbg_ovr_o  (ovr),
        .clk_en_o   (clk_en),
        .clk_hw_o   (clk_hw)
    );

    function automatic logic [31:0] bitv(input int b);
        return 32'd1 << b;
    endfunction

    function automatic logic [31:0] exp_ctl(input int i);
        logic [31:0] w;
        w = bitv(8) | bitv(9) | bitv(10) | bitv(12) | bitv(14) | bitv(15) | (32'd16 << 16);
        if (i >= C1) w = w & ~(bitv(14) | bitv(15));
        if (i >= C2) w = w | bitv(0) | bitv(1);
        if (i >= C4) w = w & ~bitv(8);
        if (i >= C6) w = w & ~(bitv(10) | bitv(12));
        if (i >= C7) w = w | bitv(28);
        return w;
    endfunction

    function automatic string tag_of(input int i);
        if (i < C1) return "R3";
        if (i < C3) return "R4";
        if (i < C5) return "R5";
        if (i < C7) return "R6";
        if (i <= C8) return "R8";
        return "R9";
    endfunction

    task automatic check_vals(input logic [31:0] ectl, input logic [31:0] eovr,
                              input logic een, input logic ehw, input logic ebusy,
                              input logic edone, input string tag);
        checks++;
        if (ctl !== ectl || ovr !== eovr || clk_en !== een || clk_hw !== ehw
            || busy !== ebusy || done !== edone) begin
            errors++;
            $display("FAIL %s: ctl=%h ovr=%h en=%b hw=%b busy=%b done=%b expected ctl=%h ovr=%h en=%b hw=%b busy=%b done=%b",
                     tag, ctl, ovr, clk_en, clk_hw, busy, done,
                     ectl, eovr, een, ehw, ebusy, edone);
        end
    endtask

    task automatic check_idx(input int i, input string extra);
        check_vals(exp_ctl(i), (i < C5) ? bitv(22) : 32'd0, i >= C3, i >= C8,
                   i < C8, i == C8, {tag_of(i), " R7", extra});
    endtask

    // start must already be driven when pre=1
    task automatic run_seq(input int inj, input bit chain, input bit pre);
        int last;
        if (!pre) begin
            @(negedge clk);
            start = 1'b1;
            hs_up = 1'b0;
        end
        last = chain ? C8 : C8 + 2;
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            start = 1'b0;
            hs_up = 1'b0;
            check_idx(i, (inj >= 0) ? " R10" : (pre ? " R11" : ""));
            if (i == inj) begin
                start = 1'b1;
                hs_up = inj[0];
            end
            if (chain && i == C8) begin
                start = 1'b1;
                hs_up = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_vals(bitv(8) | bitv(10) | bitv(12), 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        end

        // skip from the reset state
        start = 1'b1;
        hs_up = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hs_up = 1'b0;
        check_vals(bitv(8) | bitv(10) | bitv(12), 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        @(negedge clk);
        check_vals(bitv(8) | bitv(10) | bitv(12), 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

        // undisturbed run, then sweep of starts and status flips while busy
        run_seq(-1, 1'b0, 1'b0);
        for (int k = 0; k < C8; k += 11) run_seq(k, 1'b0, 1'b0);
        run_seq(C8 - 1, 1'b0, 1'b0);

        // skip after completion keeps the final state
        @(negedge clk);
        start = 1'b1;
        hs_up = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hs_up = 1'b0;
        check_vals(exp_ctl(C8), 32'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
        @(negedge clk);
        check_vals(exp_ctl(C8), 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");

        // restart in the done cycle, then a normal rerun
        run_seq(-1, 1'b1, 1'b0);
        run_seq(-1, 1'b0, 1'b1);
        run_seq(-1, 1'b0, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule